// File: doc/BRIEF.md
# Line-Buffered Vertical FIR Filter

This block filters a raster video stream in the vertical direction. Each valid pixel is combined with the pixels at the same column in the seven lines received before it. The eight vertically aligned samples are multiplied by an 8-entry coefficient set and summed into a signed 32-bit result. Seven internal line stores, each as long as one video line, hold the earlier lines. The line stores shift one line down on every pixel.

The line length is an input and may be anything from 4 pixels up to the `MAX_LEN` parameter. A line holding several interleaved channels is filtered as one long line, so no splitting into separate streams is needed. Coefficients sit in a bank of `NSETS` sets. A per-pixel set index picks the set for that pixel. A write port rewrites one coefficient at a time, and no other coefficient changes. Output rounding and limiting happen downstream of this block.

Top module: `vfir_line8`

## Requirements
- R1: After reset, `out_valid` is 0, every stored coefficient reads as zero, and the column and line counts start at zero.
- R2: `out_valid` stays 0 until seven complete lines of valid pixels (7 × `line_len`) have been accepted since reset. From the first pixel of the eighth line onward, every valid pixel produces an output.
- R3: One clock after a valid pixel P at column c, `out_valid` is 1 and `out_data` equals the sum over k = 0..7 of coef[set][k] × (pixel at column c, k lines earlier), where tap k = 0 is P itself. All operands are 12-bit two's complement, and the sum is a 32-bit two's complement word.
- R4: A cycle with `pix_valid` = 0 leaves the column position and line history unchanged and gives `out_valid` = 0 on the next clock.
- R5: The column wraps to 0 after `line_len` valid pixels, for any `line_len` from 4 to `MAX_LEN`. An interleaved multi-channel line is handled as a single line of that total length.
- R6: With `cw_en` = 1, `cw_data` is written to tap `cw_tap` of set `cw_set` at the clock edge. A pixel in that same cycle still uses the old value, and later pixels use the new one. All other coefficients keep their values.
- R7: `set_sel` picks the coefficient set for each pixel independently and may change on every cycle.
- R8: Extreme operands (−2048 and +2047 on all taps and pixels) give the exact sum with no wrap, for example 8 × (−2048)² = 33554432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | 12 | Pixel, two's complement |
| line_len | input | LEN_W | Pixels per line, 4..MAX_LEN |
| set_sel | input | SET_W | Coefficient set for this pixel |
| cw_en | input | 1 | Coefficient write strobe |
| cw_set | input | SET_W | Set to write |
| cw_tap | input | TAP_W | Tap to write |
| cw_data | input | 12 | Coefficient value, two's complement |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | Filter result, two's complement |

## Verification
The bench builds the filter with `MAX_LEN` = 16 and `NSETS` = 4. The short lines let eight-line priming finish within a few hundred cycles. They also allow the maximum line length, the minimum of 4 and an odd interleaved length of 7 to be run after separate resets. With only four sets, the per-pixel set switching and mid-stream rewrites of a single coefficient hit sets that are in active use. This shows that untouched sets keep producing the model's results.

// File: rtl/vfir_pkg.sv
package vfir_pkg;
  localparam int PIX_W  = 12;
  localparam int COEF_W = 12;
  localparam int ACC_W  = 32;

  typedef logic signed [PIX_W-1:0]  pix_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // One tap: sign-extend both operands, then multiply at full result width.
  function automatic acc_t tap_product(input pix_t p, input coef_t c);
    acc_t pe;
    acc_t ce;
    pe = acc_t'(p);
    ce = acc_t'(c);
    return pe * ce;
  endfunction
endpackage

// File: rtl/vfir_linechain.sv
module vfir_linechain
  import vfir_pkg::*;
#(
  parameter int TAPS    = 8,
  parameter int MAX_LEN = 256,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int ADDR_W = $clog2(MAX_LEN),
  localparam int LCNT_W = $clog2(TAPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pix_valid,
  input  logic [PIX_W-1:0]            pix_data,
  input  logic [LEN_W-1:0]            line_len,
  output logic [TAPS-1:0][PIX_W-1:0]  taps,
  output logic [ADDR_W-1:0]           col_q,
  output logic                        line_wrap,
  output logic                        primed
);
  logic [LCNT_W-1:0] lines_q;
  logic [PIX_W-1:0]  rd_w [TAPS-1];

  assign line_wrap = pix_valid && (LEN_W'(col_q) >= line_len - LEN_W'(1));
  assign primed    = (lines_q == LCNT_W'(TAPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q   <= '0;
      lines_q <= '0;
    end else if (pix_valid) begin
      col_q <= line_wrap ? '0 : col_q + ADDR_W'(1);
      if (line_wrap && !primed) lines_q <= lines_q + LCNT_W'(1);
    end
  end

  assign taps[0] = pix_data;

  // Store b holds the line that is b+1 lines old; each pixel shifts one store down.
  for (genvar b = 0; b < TAPS - 1; b++) begin : g_store
    logic [PIX_W-1:0] mem [MAX_LEN];
    logic [PIX_W-1:0] wr_w;
    if (b == 0) begin : g_head
      assign wr_w = pix_data;
    end else begin : g_link
      assign wr_w = rd_w[b-1];
    end
    assign rd_w[b]   = mem[col_q];
    assign taps[b+1] = rd_w[b];
    always_ff @(posedge clk) begin
      if (pix_valid) mem[col_q] <= wr_w;
    end
  end
endmodule

// File: rtl/vfir_coefbank.sv
module vfir_coefbank
  import vfir_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int NSETS  = 256,
  localparam int SET_W = $clog2(NSETS),
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SET_W-1:0]             set_sel,
  input  logic                         cw_en,
  input  logic [SET_W-1:0]             cw_set,
  input  logic [TAP_W-1:0]             cw_tap,
  input  logic [COEF_W-1:0]            cw_data,
  output logic [TAPS-1:0][COEF_W-1:0]  coefs
);
  logic [COEF_W-1:0] bank [NSETS][TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++)
        for (int k = 0; k < TAPS; k++)
          bank[s][k] <= '0;
    end else if (cw_en) begin
      bank[cw_set][cw_tap] <= cw_data;
    end
  end

  always_comb begin
    for (int k = 0; k < TAPS; k++) coefs[k] = bank[set_sel][k];
  end
endmodule

// File: rtl/vfir_mac.sv
module vfir_mac
  import vfir_pkg::*;
#(
  parameter int TAPS = 8
) (
  input  logic [TAPS-1:0][PIX_W-1:0]  taps,
  input  logic [TAPS-1:0][COEF_W-1:0] coefs,
  output logic [ACC_W-1:0]            sum
);
  always_comb begin
    acc_t acc;
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + tap_product(pix_t'(taps[k]), coef_t'(coefs[k]));
    sum = acc;
  end
endmodule

// File: rtl/vfir_line8.sv
module vfir_line8
  import vfir_pkg::*;
#(
  parameter int TAPS    = 8,
  parameter int MAX_LEN = 256,
  parameter int NSETS   = 256,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int ADDR_W = $clog2(MAX_LEN),
  localparam int SET_W  = $clog2(NSETS),
  localparam int TAP_W  = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic [LEN_W-1:0]  line_len,
  input  logic [SET_W-1:0]  set_sel,
  input  logic              cw_en,
  input  logic [SET_W-1:0]  cw_set,
  input  logic [TAP_W-1:0]  cw_tap,
  input  logic [COEF_W-1:0] cw_data,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);
  logic [TAPS-1:0][PIX_W-1:0]  taps;
  logic [TAPS-1:0][COEF_W-1:0] coefs;
  logic [ACC_W-1:0]            sum;
  logic [ADDR_W-1:0]           col_q;
  logic                        line_wrap;
  logic                        primed;
  logic                        fire;

  vfir_linechain #(.TAPS(TAPS), .MAX_LEN(MAX_LEN)) u_chain (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .line_len(line_len), .taps(taps), .col_q(col_q), .line_wrap(line_wrap),
    .primed(primed)
  );

  vfir_coefbank #(.TAPS(TAPS), .NSETS(NSETS)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .cw_en(cw_en),
    .cw_set(cw_set), .cw_tap(cw_tap), .cw_data(cw_data), .coefs(coefs)
  );

  vfir_mac #(.TAPS(TAPS)) u_mac (.taps(taps), .coefs(coefs), .sum(sum));

  assign fire = pix_valid && primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= sum;
    end
  end
endmodule

// File: rtl/vfir_chk.sv
module vfir_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              primed,
  input logic              line_wrap,
  input logic [ADDR_W-1:0] col_q,
  input logic              out_valid
);
  // R2
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !out_valid);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  // R4
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(col_q));
  // R5
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_wrap) |=> (col_q == $past(col_q) + ADDR_W'(1)));
  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_wrap |=> (col_q == '0));
endmodule

bind vfir_line8 vfir_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .primed(primed),
  .line_wrap(line_wrap), .col_q(col_q), .out_valid(out_valid)
);

// File: tb/tb_vfir_line8.sv
`timescale 1ns/1ps
module tb_vfir_line8;
  localparam int ML = 16;
  localparam int NS = 4;
  localparam int LW = $clog2(ML + 1);
  localparam int SW = $clog2(NS);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          pix_valid = 1'b0;
  logic [11:0]   pix_data = '0;
  logic [LW-1:0] line_len = LW'(4);
  logic [SW-1:0] set_sel = '0;
  logic          cw_en = 1'b0;
  logic [SW-1:0] cw_set = '0;
  logic [2:0]    cw_tap = '0;
  logic [11:0]   cw_data = '0;
  logic          out_valid;
  logic [31:0]   out_data;

  vfir_line8 #(.MAX_LEN(ML), .NSETS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .line_len(line_len), .set_sel(set_sel), .cw_en(cw_en), .cw_set(cw_set),
    .cw_tap(cw_tap), .cw_data(cw_data), .out_valid(out_valid), .out_data(out_data)
  );

  int    coef_m [NS][8];
  int    hist[$];
  int    cur_len;
  bit    pend_v;
  int    pend_d;
  string pend_req;
  string req;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  task automatic compare();
    n_chk++;
    if (out_valid !== pend_v) begin
      n_fail++;
      $display("FAIL %s out_valid act=%0b exp=%0b", pend_req, out_valid, pend_v);
    end else if (pend_v && ($signed(out_data) != pend_d)) begin
      n_fail++;
      $display("FAIL %s out_data act=%0d exp=%0d", pend_req, $signed(out_data), pend_d);
    end
  endtask

  // One clock: check the result of the previous cycle, then drive and model this one.
  task automatic cycle(input bit v, input int d, input int sel,
                       input bit we, input int ws, input int wt, input int wd);
    @(negedge clk);
    compare();
    pix_valid = v;
    pix_data  = d[11:0];
    set_sel   = SW'(sel);
    cw_en     = we;
    cw_set    = SW'(ws);
    cw_tap    = 3'(wt);
    cw_data   = wd[11:0];
    pend_v = 1'b0;
    pend_d = 0;
    if (v) begin
      int n;
      hist.push_back(d);
      n = hist.size();
      if (n - 1 >= 7 * cur_len) begin
        pend_v = 1'b1;
        for (int k = 0; k < 8; k++) pend_d += coef_m[sel][k] * hist[n - 1 - k * cur_len];
      end
    end
    pend_req = !v ? "R4" : (!pend_v ? "R2" : req);
    if (we) coef_m[ws][wt] = wd;
  endtask

  task automatic do_reset(input int len);
    @(negedge clk);
    rst_n = 1'b0;
    pix_valid = 1'b0;
    cw_en = 1'b0;
    line_len = LW'(len);
    cur_len = len;
    hist.delete();
    for (int s = 0; s < NS; s++) for (int k = 0; k < 8; k++) coef_m[s][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pend_v = 1'b0;
    pend_req = "R1";
  endtask

  function automatic int rnd12();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  task automatic load_all(input int fixed, input bit use_fixed);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 8; k++)
        cycle(1'b0, 0, 0, 1'b1, s, k, use_fixed ? fixed : rnd12());
  endtask

  task automatic stream(input int npix, input int mode, input bit gaps);
    for (int i = 0; i < npix; i++) begin
      int sel;
      sel = (mode == 0) ? 0 : (i % NS);
      if (gaps && (i % 5 == 2)) cycle(1'b0, 0, sel, 1'b0, 0, 0, 0);
      cycle(1'b1, rnd12(), sel, 1'b0, 0, 0, 0);
    end
  endtask

  initial begin
    void'($urandom(7));
    // R1: reset state, coefficients read as zero once primed
    req = "R1";
    do_reset(4);
    cycle(1'b0, 0, 0, 1'b0, 0, 0, 0);
    stream(4 * 9, 1, 1'b0);

    // R3 and R4: random coefficients, minimum line length, idle gaps
    req = "R3";
    do_reset(4);
    load_all(0, 1'b0);
    stream(4 * 12, 0, 1'b1);

    // R5 at maximum length, R7 per-pixel set changes
    req = "R7";
    do_reset(ML);
    load_all(0, 1'b0);
    stream(ML * 9, 1, 1'b0);

    // R6: single-coefficient rewrites while streaming, same-cycle pixel uses the old value
    req = "R6";
    for (int i = 0; i < 24; i++) begin
      cycle(1'b1, rnd12(), i % NS, (i % 3 == 0), 1, (i / 3) % 8, rnd12());
    end
    stream(ML * 2, 1, 1'b1);

    // R5: interleaved line of odd total length
    req = "R5";
    do_reset(7);
    load_all(0, 1'b0);
    stream(7 * 10, 1, 1'b1);

    // R8: extreme operands
    req = "R8";
    do_reset(4);
    load_all(-2048, 1'b1);
    for (int i = 0; i < 4 * 9; i++) cycle(1'b1, -2048, 0, 1'b0, 0, 0, 0);
    load_all(2047, 1'b1);
    for (int i = 0; i < 4 * 9; i++) cycle(1'b1, (i % 2 == 0) ? -2048 : 2047, i % NS, 1'b0, 0, 0, 0);
    cycle(1'b0, 0, 0, 1'b0, 0, 0, 0);
    cycle(1'b0, 0, 0, 1'b0, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule